// File: doc/BRIEF.md
# Resident-Program Streaming ALU Chain

This block is a linear pipeline of simple ALU stages. Each stage holds one resident opcode and one immediate operand, and it performs exactly one step of a straight-line program that has no branches. Every clock cycle a new data item can enter at the head. The item's working value moves one stage further down on every edge and leaves at the tail. The program therefore runs once per item, and a fresh run starts in every cycle.

The program is written once through a single load port, one stage per write. It then stays resident for as many items as are streamed. No register file holds intermediate values, because each stage hands its result directly to the next stage. Each stage also has a private local register that persists from one item to the next. A running sum or a one-item delay therefore costs a single operation per item, and no reduction tree is needed.

Loads are meant to happen while the chain is empty. The block protects itself by dropping any write that arrives while an item is entering or still in flight.

Top module: `prog_chain`

## Requirements
- R1: An asserted reset clears every local register to 0 and sets every stage's opcode to pass. After reset, out_valid is 0 and the chain returns each streamed item unchanged.
- R2: An item presented with in_valid at a rising edge appears on out_data with out_valid high exactly NSTAGE edges later. Items arriving back to back leave back to back, in the order they arrived.
- R3: The opcodes are 0 pass, 1 add immediate, 2 multiply by immediate (low DW bits), 3 subtract immediate and 7 unsigned maximum with the immediate. Arithmetic wraps modulo 2^DW.
- R4: Opcode 4 adds the incoming value to the stage's local register and forwards the updated sum.
- R5: Opcode 5 forwards the current local register value and stores the incoming value in its place, which delays the stream by one item.
- R6: Opcode 6 forwards the incoming value unchanged and holds the local register at 0.
- R7: A local register changes only when a valid item passes through its stage. Cycles without a valid item leave it untouched.
- R8: A load with ld_en, ld_idx, ld_op and ld_imm writes that stage's opcode and immediate, which then stay in effect for every later item until that stage is rewritten. The write also clears that stage's local register.
- R9: A load is ignored when in_valid is high, when any item is still in flight inside the chain, or when ld_idx is NSTAGE or larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously |
| ld_en | input | 1 | Program write strobe |
| ld_idx | input | IW = max(1, clog2(NSTAGE)) | Index of the stage to write |
| ld_op | input | 3 | Opcode to store |
| ld_imm | input | DW | Immediate operand to store |
| in_valid | input | 1 | Head item valid |
| in_data | input | DW | Head item value |
| out_valid | output | 1 | Tail item valid |
| out_data | output | DW | Tail item value |

## Verification
Two functions can coincide in the same cycle: a program write and a streamed item, either one entering at the head or one still travelling through the stages. The bench raises ld_en in the same cycle as an entering item, and again in a cycle where in_valid is low but items are still in flight. Each of these writes targets a stage with an opcode that would change every result. The bench then drains the chain and streams more items. A write that was wrongly accepted would show up as output values that differ from the arithmetic model, which still holds the old program.

// File: rtl/chain_pkg.sv
package chain_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADDI = 3'd1,
    OP_MULI = 3'd2,
    OP_SUBI = 3'd3,
    OP_ACC  = 3'd4,
    OP_EMIT = 3'd5,
    OP_CLR  = 3'd6,
    OP_MAXI = 3'd7
  } chain_op_e;

endpackage

// File: rtl/chain_rst_sync.sv
module chain_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/chain_loader.sv
module chain_loader #(
  parameter int NSTAGE = 8,
  parameter int IW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_idx,
  input  logic              in_valid,
  input  logic [NSTAGE-1:0] stage_vld,
  output logic [NSTAGE-1:0] wr_vec
);

  logic busy;
  logic ld_ok;

  always_comb begin
    busy  = in_valid | (|stage_vld);
    ld_ok = ld_en & ~busy;
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_dec
    always_comb begin
      wr_vec[g] = ld_ok & (ld_idx == IW'(g));
    end
  end

  // R9: at most one stage is written per cycle
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  // R9: no write while an item is being presented at the head
  a_r9_head_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (wr_vec == '0));

endmodule

// File: rtl/chain_stage.sv
module chain_stage
  import chain_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  chain_op_e     wr_op,
  input  logic [DW-1:0] wr_imm,
  input  logic          in_vld,
  input  logic [DW-1:0] in_dat,
  output logic          out_vld,
  output logic [DW-1:0] out_dat
);

  chain_op_e     op_q,  op_d;
  logic [DW-1:0] imm_q, imm_d;
  logic [DW-1:0] loc_q, loc_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          vld_q, vld_d;

  logic [DW-1:0] res;
  logic [DW-1:0] loc_upd;
  logic          prog_en;
  logic          loc_en;
  logic          dat_en;

  // Operation select: the opcode only steers muxes and the ALU function.
  always_comb begin
    res     = in_dat;
    loc_upd = loc_q;
    case (op_q)
      OP_PASS: res = in_dat;
      OP_ADDI: res = in_dat + imm_q;
      OP_MULI: res = in_dat * imm_q;
      OP_SUBI: res = in_dat - imm_q;
      OP_ACC: begin
        loc_upd = loc_q + in_dat;
        res     = loc_q + in_dat;
      end
      OP_EMIT: begin
        loc_upd = in_dat;
        res     = loc_q;
      end
      OP_CLR: begin
        loc_upd = '0;
        res     = in_dat;
      end
      OP_MAXI: res = (in_dat > imm_q) ? in_dat : imm_q;
      default: res = in_dat;
    endcase
  end

  // Clock enables and next state.
  always_comb begin
    prog_en = wr_en;
    loc_en  = wr_en | in_vld;
    dat_en  = in_vld;

    op_d  = prog_en ? wr_op  : op_q;
    imm_d = prog_en ? wr_imm : imm_q;
    if (wr_en) begin
      loc_d = '0;
    end else if (in_vld) begin
      loc_d = loc_upd;
    end else begin
      loc_d = loc_q;
    end
    dat_d = dat_en ? res : dat_q;
    vld_d = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_PASS;
      imm_q <= '0;
      loc_q <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (prog_en) begin
        op_q  <= op_d;
        imm_q <= imm_d;
      end
      if (loc_en) begin
        loc_q <= loc_d;
      end
      if (dat_en) begin
        dat_q <= dat_d;
      end
      vld_q <= vld_d;
    end
  end

  assign out_vld = vld_q;
  assign out_dat = dat_q;

  // R9: a write never lands on a stage that is receiving an item
  a_r9_no_write_on_item: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_vld);

  // R7: the local register is untouched in a bubble
  a_r7_bubble_keeps_local: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && !wr_en) |=> $stable(loc_q));

  // R8: a program write leaves the local register at zero
  a_r8_write_clears_local: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (loc_q == '0));

  // R6: a clearing stage holds zero after each item
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_CLR && in_vld && !wr_en) |=> (loc_q == '0));

  // R2: a valid item advances one stage per edge
  a_r2_valid_advances: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> vld_q);

endmodule

// File: rtl/prog_chain.sv
module prog_chain
  import chain_pkg::*;
#(
  parameter int  NSTAGE = 8,
  parameter int  DW     = 32,
  localparam int IW     = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [2:0]    ld_op,
  input  logic [DW-1:0] ld_imm,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  logic              srst_n;
  logic [NSTAGE:0]   vld_w;
  logic [DW-1:0]     dat_w [NSTAGE+1];
  logic [NSTAGE-1:0] wr_vec;
  chain_op_e         wr_op;

  chain_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  chain_loader #(.NSTAGE(NSTAGE), .IW(IW)) u_ld (
    .clk       (clk),
    .rst_n     (srst_n),
    .ld_en     (ld_en),
    .ld_idx    (ld_idx),
    .in_valid  (in_valid),
    .stage_vld (vld_w[NSTAGE:1]),
    .wr_vec    (wr_vec)
  );

  assign wr_op    = chain_op_e'(ld_op);
  assign vld_w[0] = in_valid;
  assign dat_w[0] = in_data;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    chain_stage #(.DW(DW)) u_stg (
      .clk     (clk),
      .rst_n   (srst_n),
      .wr_en   (wr_vec[s]),
      .wr_op   (wr_op),
      .wr_imm  (ld_imm),
      .in_vld  (vld_w[s]),
      .in_dat  (dat_w[s]),
      .out_vld (vld_w[s+1]),
      .out_dat (dat_w[s+1])
    );
  end

  assign out_valid = vld_w[NSTAGE];
  assign out_data  = dat_w[NSTAGE];

  // R9: writes only happen with the whole chain empty
  a_r9_load_when_drained: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_vec != '0) |-> (vld_w == '0));

endmodule

// File: tb/tb_prog_chain.sv
`timescale 1ns/1ps
module tb_prog_chain;

  localparam int N  = 5;
  localparam int DW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_en;
  logic [IW-1:0] ld_idx;
  logic [2:0]    ld_op;
  logic [DW-1:0] ld_imm;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [2:0]    m_op  [N];
  logic [DW-1:0] m_imm [N];
  logic [DW-1:0] m_loc [N];

  logic [DW-1:0] exp_q [$];
  int            tim_q [$];
  string         tag_q [$];

  logic [DW-1:0] lfsr = 32'hACE1_2468;

  prog_chain #(.NSTAGE(N), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_op(ld_op),
    .ld_imm(ld_imm), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] model(input logic [DW-1:0] x);
    logic [DW-1:0] v;
    logic [DW-1:0] t;
    v = x;
    for (int s = 0; s < N; s++) begin
      case (m_op[s])
        3'd1: v = v + m_imm[s];
        3'd2: v = v * m_imm[s];
        3'd3: v = v - m_imm[s];
        3'd4: begin m_loc[s] = m_loc[s] + v; v = m_loc[s]; end
        3'd5: begin t = m_loc[s]; m_loc[s] = v; v = t; end
        3'd6: m_loc[s] = '0;
        3'd7: if (m_imm[s] > v) v = m_imm[s];
        default: v = v;
      endcase
    end
    return v;
  endfunction

  function automatic logic [DW-1:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output monitor: data and latency of every item leaving the tail.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected item", out_data, '0);
      end else begin
        logic [DW-1:0] e;
        int            t;
        string         g;
        e = exp_q.pop_front();
        t = tim_q.pop_front();
        g = tag_q.pop_front();
        check(out_data == e, g, out_data, e);
        check(cyc == t + N, "R2 latency", DW'(cyc), DW'(t + N));
      end
    end
  end

  task automatic push(input logic [DW-1:0] x, input string tag);
    in_valid = 1'b1;
    in_data  = x;
    exp_q.push_back(model(x));
    tim_q.push_back(cyc);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic bubble();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    repeat (N + 3) @(negedge clk);
  endtask

  task automatic load(input int idx, input logic [2:0] op, input logic [DW-1:0] imm);
    ld_en  = 1'b1;
    ld_idx = IW'(idx);
    ld_op  = op;
    ld_imm = imm;
    @(negedge clk);
    ld_en = 1'b0;
    if (idx < N) begin
      m_op[idx]  = op;
      m_imm[idx] = imm;
      m_loc[idx] = '0;
    end
  endtask

  task automatic all_pass();
    for (int s = 0; s < N; s++) load(s, 3'd0, '0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string tg;
    rst_n = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_op = '0; ld_imm = '0;
    in_valid = 1'b0; in_data = '0;
    for (int s = 0; s < N; s++) begin m_op[s] = 3'd0; m_imm[s] = '0; m_loc[s] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", DW'(out_valid), '0);
    push(32'h1234_5678, "R1 identity after reset");
    push(32'hFFFF_FFFF, "R1 identity after reset");
    push(32'h0000_0000, "R1 identity after reset");
    drain();

    // R3..R7: each opcode at each position, back-to-back with one bubble
    for (int st = 0; st < N; st++) begin
      for (int op = 0; op < 8; op++) begin
        all_pass();
        load(st, 3'(op), 32'h8000_0003 + DW'(st * 977 + op * 13));
        case (op)
          4: tg = "R4 accumulate";
          5: tg = "R5 emit";
          6: tg = "R6 clear";
          default: tg = "R3 alu op";
        endcase
        push(32'h0000_0000, tg);
        push(32'hFFFF_FFFF, tg);
        bubble();
        bubble();
        push(32'h8000_0000, {tg, " R7 after bubble"});
        push(next_rand(), tg);
        push(32'h0000_0001, tg);
        push(next_rand(), tg);
        drain();
      end
    end

    // R2: mixed program, long stream with periodic bubbles
    load(0, 3'd1, 32'd5);
    load(1, 3'd4, 32'd0);
    load(2, 3'd2, 32'd3);
    load(3, 3'd5, 32'd0);
    load(4, 3'd7, 32'd100);
    for (int i = 0; i < 30; i++) begin
      if (i % 4 == 3) bubble();
      push(next_rand() >> (i % 28), "R2 mixed program");
    end
    drain();

    // R9: write attempted alongside an entering item
    ld_en = 1'b1; ld_idx = IW'(2); ld_op = 3'd2; ld_imm = '0;
    push(32'h0000_0777, "R9 load with head item");
    ld_en = 1'b1; ld_idx = IW'(4); ld_op = 3'd2; ld_imm = '0;
    in_valid = 1'b0;
    @(negedge clk);
    // R9: write attempted with items still in flight
    ld_en = 1'b1; ld_idx = IW'(0); ld_op = 3'd2; ld_imm = '0;
    @(negedge clk);
    ld_en = 1'b0;
    drain();
    // R9: out-of-range indices
    for (int k = N; k < 8; k++) begin
      ld_en = 1'b1; ld_idx = IW'(k); ld_op = 3'd2; ld_imm = '0;
      @(negedge clk);
    end
    ld_en = 1'b0;
    for (int i = 0; i < 6; i++) push(next_rand(), "R9 program unchanged");
    drain();

    // R8: program stays resident; rewriting a stage restarts its sum
    all_pass();
    load(2, 3'd4, 32'd0);
    for (int i = 1; i <= 5; i++) push(DW'(i * 10), "R8 resident accumulate");
    drain();
    for (int i = 1; i <= 3; i++) push(DW'(i), "R8 resident accumulate continues");
    drain();
    load(2, 3'd4, 32'd0);
    for (int i = 1; i <= 3; i++) push(DW'(i), "R8 rewrite clears local");
    drain();

    check(exp_q.size() == 0, "R2 all items delivered", DW'(exp_q.size()), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule